// File: doc/BRIEF.md
# OTP memory write command sequencer

This block is the byte-level slave engine behind the two write commands of a one-time-programmable memory reached over a single-wire bus. A bit-level front end hands it each received byte, asks it for each byte to send back, and forwards two strobes: the program pulse and the bus reset. One command writes the data EPROM array. The other writes the status space. That space holds a few EPROM bytes at the low addresses and one volatile register above them.

A write pass works like this. The host sends a byte, and the block places it in a one-byte scratchpad. The block then returns an inverted CRC16 so the host can check what was received. On a program pulse the block commits the scratchpad. It then returns the byte read back from the target. If that byte matches and the end of the space has not been reached, the address steps forward. The CRC is reseeded with the new address, and the next data byte starts a new pass. When any check fails, the block goes quiet until the host resets the bus.

Top module: `otp_wr_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `tx_valid` and `presence` are 0. After reset every data and status EPROM byte reads FFh and the volatile status register reads 00h.
- R2: In idle, the command byte 0Fh starts a data write and 55h starts a status write. Any other command byte makes the block ignore all input except `bus_reset`.
- R3: The two address bytes follow the command, bits 7:0 first and then bits 15:8. Data memory is indexed by the address modulo `DATA_BYTES`.
- R4: The CRC16 uses polynomial x^16+x^15+x^2+1, shifted LSB first from a zero seed. On the first pass it covers the command, the low address byte, the high address byte and the data byte. The first and second `tx_req` after the data byte return bits 7:0 and then bits 15:8 of the inverted CRC.
- R5: On every later pass the CRC covers only the new address (low byte, then high byte) and the new data byte.
- R6: After the CRC has been sent, a received byte that is not an accepted volatile confirmation commits nothing, and the block ignores all input until `bus_reset`.
- R7: A program pulse commits to EPROM as a bitwise AND: the stored byte becomes the old value AND the scratchpad.
- R8: A status address below `STAT_EPROM` selects a status EPROM byte and is committed only by a program pulse. A status address of `STAT_EPROM` or above selects the volatile register. That register is overwritten by either a program pulse or a received FFh.
- R9: After the commit, the next `tx_req` returns the byte read from the target. If it equals the scratchpad and the address is not the last, the address increments by one and the next received byte is the new data byte.
- R10: A readback mismatch, or a completed pass at the last location, makes the block ignore all input except `bus_reset`. The last location is data index `DATA_BYTES-1`, or any volatile status address.
- R11: `bus_reset` aborts any sequence in any state, returns the block to idle and raises `presence` for one cycle on the next clock.
- R12: `tx_valid` rises for one cycle in the clock after a `tx_req` only while a CRC or readback byte is due. Otherwise `tx_req` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Byte from host is present on `rx_byte` |
| rx_byte | input | 8 | Byte received from host |
| tx_req | input | 1 | Front end asks for the next byte to send |
| tx_valid | output | 1 | `tx_byte` answers the previous cycle's request |
| tx_byte | output | 8 | Byte to send to host |
| prog_pulse | input | 1 | Program pulse strobe from host |
| bus_reset | input | 1 | Bus reset strobe from host |
| presence | output | 1 | One-cycle presence answer to a bus reset |

## Verification
The bench builds the block with its default sizes: 128 data bytes and 7 status EPROM bytes, so the volatile register sits at status address 7. With these sizes a data write that starts at address 017Eh exercises the modulo indexing and runs into the last data location within two passes. A status write that starts at address 6 crosses from EPROM into the volatile register and ends there. An earlier write to the same data address makes the AND-only commit produce a readback mismatch.

// File: rtl/otp_wr_pkg.sv
// Package: shared state encoding, command codes and the CRC16 byte step
// for the OTP write sequencer. Assumes reflected CRC16 arithmetic.
package otp_wr_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_ADDR_LO, S_ADDR_HI, S_DATA,
        S_CRC_LO, S_CRC_HI, S_WAIT_PROG, S_READBACK, S_HALT
    } seq_state_t;

    localparam logic [7:0]  CMD_WR_DATA   = 8'h0F;
    localparam logic [7:0]  CMD_WR_STAT   = 8'h55;
    localparam logic [7:0]  VOL_CONFIRM   = 8'hFF;
    localparam logic [15:0] CRC_POLY_REFL = 16'hA001;

    // Shift one byte into the CRC, least significant bit first.
    function automatic logic [15:0] crc16_step(input logic [15:0] c_in,
                                               input logic [7:0]  b);
        logic [15:0] c;
        logic        fb;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ b[i];
            c  = c >> 1;
            if (fb) c = c ^ CRC_POLY_REFL;
        end
        return c;
    endfunction

endpackage

// File: rtl/otp_crc16.sv
// Running CRC16 register. Clears, absorbs one byte, or reseeds itself
// from a 16-bit address (low byte first) in one cycle.
// Assumes at most one of ld_addr / upd is meaningful per cycle; ld_addr wins.
module otp_crc16
    import otp_wr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        upd,
    input  logic [7:0]  din,
    input  logic        ld_addr,
    input  logic [15:0] addr,
    output logic [15:0] crc
);

    // Update the CRC register according to the control strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            crc <= 16'h0000;
        else if (ld_addr)
            crc <= crc16_step(crc16_step(16'h0000, addr[7:0]), addr[15:8]);
        else if (upd)
            crc <= crc16_step(clr ? 16'h0000 : crc, din);
        else if (clr)
            crc <= 16'h0000;
    end

endmodule

// File: rtl/otp_store.sv
// Target storage: data EPROM array, status EPROM bytes and one volatile
// status register. EPROM writes only clear bits; the volatile register is
// overwritten. Read port is combinational on the current address.
// Assumes STAT_EPROM >= 2 and DATA_BYTES a power of two.
module otp_store #(
    parameter int DATA_BYTES = 128,
    parameter int STAT_EPROM = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic        sel_stat,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        is_vol,
    output logic        at_end
);

    localparam int DIDX_W = $clog2(DATA_BYTES);
    localparam int SIDX_W = $clog2(STAT_EPROM);

    logic [7:0]        data_mem [DATA_BYTES];
    logic [7:0]        stat_mem [STAT_EPROM];
    logic [7:0]        vol_reg;
    logic [DIDX_W-1:0] didx;
    logic [SIDX_W-1:0] sidx;

    assign didx   = addr[DIDX_W-1:0];
    assign sidx   = addr[SIDX_W-1:0];
    assign is_vol = sel_stat && (addr >= 16'(STAT_EPROM));
    assign at_end = sel_stat ? is_vol : (didx == DIDX_W'(DATA_BYTES - 1));

    // Data EPROM: erased to FFh, commit ANDs the scratchpad in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DATA_BYTES; i++) data_mem[i] <= 8'hFF;
        end else if (we && !sel_stat) begin
            data_mem[didx] <= data_mem[didx] & wdata;
        end
    end

    // Status EPROM bytes, one cell per location.
    for (genvar g = 0; g < STAT_EPROM; g++) begin : g_stat
        always_ff @(posedge clk) begin
            if (!rst_n)
                stat_mem[g] <= 8'hFF;
            else if (we && sel_stat && !is_vol && sidx == SIDX_W'(g))
                stat_mem[g] <= stat_mem[g] & wdata;
        end
    end

    // Volatile status register: plain overwrite.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vol_reg <= 8'h00;
        else if (we && is_vol)
            vol_reg <= wdata;
    end

    // Read mux for the readback byte.
    always_comb begin
        if (!sel_stat)   rdata = data_mem[didx];
        else if (is_vol) rdata = vol_reg;
        else             rdata = stat_mem[sidx];
    end

endmodule

// File: rtl/otp_wr_seq.sv
// Top: byte-level write command sequencer. Decodes the command, collects
// the address and data, returns the CRC, commits on program pulse (or FFh
// for the volatile register), returns the readback and loops.
// Assumes rx_valid, tx_req, prog_pulse and bus_reset are one-cycle strobes.
module otp_wr_seq
    import otp_wr_pkg::*;
#(
    parameter int DATA_BYTES = 128,
    parameter int STAT_EPROM = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       tx_req,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    input  logic       prog_pulse,
    input  logic       bus_reset,
    output logic       presence
);

    seq_state_t  state;
    logic [15:0] addr;
    logic [7:0]  scratch;
    logic        sel_stat;
    logic [15:0] crc;
    logic        crc_clr, crc_upd, crc_ld, st_we;
    logic [7:0]  rdata;
    logic        is_vol, at_end, cmd_ok, pass_ok;
    logic [15:0] addr_nxt;

    assign cmd_ok   = (rx_byte == CMD_WR_DATA) || (rx_byte == CMD_WR_STAT);
    assign pass_ok  = (rdata == scratch) && !at_end;
    assign addr_nxt = addr + 16'd1;

    otp_crc16 u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .upd(crc_upd),
        .din(rx_byte), .ld_addr(crc_ld), .addr(addr_nxt), .crc(crc)
    );

    otp_store #(.DATA_BYTES(DATA_BYTES), .STAT_EPROM(STAT_EPROM)) u_store (
        .clk(clk), .rst_n(rst_n), .we(st_we), .sel_stat(sel_stat),
        .addr(addr), .wdata(scratch), .rdata(rdata),
        .is_vol(is_vol), .at_end(at_end)
    );

    // Strobes to the CRC and storage for the current state and inputs.
    always_comb begin
        crc_clr = 1'b0;
        crc_upd = 1'b0;
        crc_ld  = 1'b0;
        st_we   = 1'b0;
        if (!bus_reset) begin
            unique case (state)
                S_IDLE:                      if (rx_valid && cmd_ok) begin
                                                 crc_clr = 1'b1;
                                                 crc_upd = 1'b1;
                                             end
                S_ADDR_LO, S_ADDR_HI, S_DATA: crc_upd = rx_valid;
                S_WAIT_PROG:                 st_we = prog_pulse ||
                                                 (rx_valid && is_vol && rx_byte == VOL_CONFIRM);
                S_READBACK:                  crc_ld = tx_req && pass_ok;
                default: ;
            endcase
        end
    end

    // Sequencer state, address, scratchpad and outgoing byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            addr     <= 16'h0000;
            scratch  <= 8'h00;
            sel_stat <= 1'b0;
            tx_valid <= 1'b0;
            tx_byte  <= 8'h00;
            presence <= 1'b0;
        end else begin
            tx_valid <= 1'b0;
            presence <= 1'b0;
            if (bus_reset) begin
                state    <= S_IDLE;
                presence <= 1'b1;
            end else begin
                unique case (state)
                    S_IDLE: if (rx_valid) begin
                        sel_stat <= (rx_byte == CMD_WR_STAT);
                        state    <= cmd_ok ? S_ADDR_LO : S_HALT;
                    end
                    S_ADDR_LO: if (rx_valid) begin
                        addr[7:0] <= rx_byte;
                        state     <= S_ADDR_HI;
                    end
                    S_ADDR_HI: if (rx_valid) begin
                        addr[15:8] <= rx_byte;
                        state      <= S_DATA;
                    end
                    S_DATA: if (rx_valid) begin
                        scratch <= rx_byte;
                        state   <= S_CRC_LO;
                    end
                    S_CRC_LO: if (tx_req) begin
                        tx_valid <= 1'b1;
                        tx_byte  <= ~crc[7:0];
                        state    <= S_CRC_HI;
                    end
                    S_CRC_HI: if (tx_req) begin
                        tx_valid <= 1'b1;
                        tx_byte  <= ~crc[15:8];
                        state    <= S_WAIT_PROG;
                    end
                    S_WAIT_PROG: begin
                        if (st_we)         state <= S_READBACK;
                        else if (rx_valid) state <= S_HALT;
                    end
                    S_READBACK: if (tx_req) begin
                        tx_valid <= 1'b1;
                        tx_byte  <= rdata;
                        if (pass_ok) begin
                            addr  <= addr_nxt;
                            state <= S_DATA;
                        end else begin
                            state <= S_HALT;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/otp_wr_seq_chk.sv
// Checker for otp_wr_seq: protocol properties on ports and sequencer state.
// Bound to every instance of the top module.
module otp_wr_seq_chk
    import otp_wr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_reset,
    input logic        tx_req,
    input logic        tx_valid,
    input logic        presence,
    input seq_state_t  state,
    input logic [15:0] addr
);

    // R11: a bus reset is answered by presence on the next clock.
    a_r11_presence_follows: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> presence);

    // R11: presence never appears without a preceding bus reset.
    a_r11_presence_cause: assert property (@(posedge clk) disable iff (!rst_n)
        presence |-> $past(bus_reset));

    // R11: bus reset returns the sequencer to idle.
    a_r11_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> state == S_IDLE);

    // R12: an outgoing byte always answers a request one cycle earlier.
    a_r12_tx_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(tx_req));

    // R10: a halted sequencer sends nothing.
    a_r10_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HALT && !bus_reset) |=> !tx_valid);

    // R9: a new pass starts at the next address.
    a_r9_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA && $past(state) == S_READBACK) |-> addr == $past(addr) + 16'd1);

endmodule

bind otp_wr_seq otp_wr_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .tx_req(tx_req),
    .tx_valid(tx_valid), .presence(presence), .state(state), .addr(addr)
);

// File: tb/test_otp_wr_seq.sv
// Bench: behavioural reference model of the write flow, compared against
// the outputs of the design on every clock.
module test_otp_wr_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_req = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       prog_pulse = 1'b0;
    logic       bus_reset = 1'b0;
    logic       presence;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    otp_wr_seq i_otp_wr_seq (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_req(tx_req), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .prog_pulse(prog_pulse), .bus_reset(bus_reset), .presence(presence)
    );

    // ---------------- reference model ----------------
    int          phase;          // 0 idle,1 alo,2 ahi,3 data,4 crcL,5 crcH,6 wait,7 rb,8 halt
    bit          m_stat, m_later, m_live;
    logic [15:0] m_addr;
    logic [7:0]  m_scr;
    logic [7:0]  m_q[$];
    logic [7:0]  m_dat[128];
    logic [7:0]  m_st[7];
    logic [7:0]  m_vol;
    bit          m_txv, m_pres;
    logic [7:0]  m_txb;
    string       m_tag, m_ptag, m_halt_tag;

    function automatic logic [15:0] crc_of_q();
        logic [15:0] c;
        logic        fb;
        c = 16'h0000;
        foreach (m_q[i])
            for (int k = 0; k < 8; k++) begin
                fb = c[0] ^ m_q[i][k];
                c  = c >> 1;
                if (fb) c = c ^ 16'hA001;
            end
        return c;
    endfunction

    function automatic bit m_is_vol();
        return m_stat && (m_addr >= 16'd7);
    endfunction

    function automatic logic [7:0] m_read();
        if (!m_stat)     return m_dat[m_addr % 128];
        if (m_is_vol())  return m_vol;
        return m_st[m_addr];
    endfunction

    function automatic void m_commit();
        if (!m_stat)         m_dat[m_addr % 128] = m_dat[m_addr % 128] & m_scr;
        else if (m_is_vol()) m_vol = m_scr;
        else                 m_st[m_addr] = m_st[m_addr] & m_scr;
    endfunction

    always @(posedge clk) begin
        logic [15:0] c;
        logic [7:0]  rb;
        bit          last;
        m_live = 1'b1;
        m_txv  = 1'b0;
        m_pres = 1'b0;
        m_ptag = "R11";
        if (!rst_n) begin
            phase = 0;
            foreach (m_dat[i]) m_dat[i] = 8'hFF;
            foreach (m_st[i])  m_st[i]  = 8'hFF;
            m_vol  = 8'h00;
            m_tag  = "R1";
            m_ptag = "R1";
        end else if (bus_reset) begin
            phase  = 0;
            m_pres = 1'b1;
            m_tag  = "R11";
        end else begin
            m_tag = "R12";
            case (phase)
                0: if (rx_valid) begin
                    if (rx_byte == 8'h0F || rx_byte == 8'h55) begin
                        m_stat  = (rx_byte == 8'h55);
                        m_later = 1'b0;
                        m_q     = {rx_byte};
                        phase   = 1;
                    end else begin
                        m_halt_tag = "R2";
                        phase      = 8;
                    end
                end
                1: if (rx_valid) begin m_addr[7:0]  = rx_byte; m_q.push_back(rx_byte); phase = 2; end
                2: if (rx_valid) begin m_addr[15:8] = rx_byte; m_q.push_back(rx_byte); phase = 3; end
                3: if (rx_valid) begin m_scr = rx_byte; m_q.push_back(rx_byte); phase = 4; end
                4, 5: begin
                    m_tag = m_later ? "R5" : "R4";
                    if (tx_req) begin
                        c     = ~crc_of_q();
                        m_txv = 1'b1;
                        m_txb = (phase == 4) ? c[7:0] : c[15:8];
                        phase = phase + 1;
                    end
                end
                6: begin
                    m_tag = "R8";
                    if (prog_pulse || (rx_valid && m_is_vol() && rx_byte == 8'hFF)) begin
                        m_commit();
                        phase = 7;
                    end else if (rx_valid) begin
                        m_halt_tag = "R6";
                        phase      = 8;
                    end
                end
                7: begin
                    m_tag = m_stat ? "R8/R9" : ((m_addr >= 16'd128) ? "R3/R9" : "R7/R9");
                    if (tx_req) begin
                        rb    = m_read();
                        last  = m_stat ? m_is_vol() : ((m_addr % 128) == 127);
                        m_txv = 1'b1;
                        m_txb = rb;
                        if (rb == m_scr && !last) begin
                            m_addr  = m_addr + 16'd1;
                            m_later = 1'b1;
                            m_q     = {m_addr[7:0], m_addr[15:8]};
                            phase   = 3;
                        end else begin
                            m_halt_tag = "R10";
                            phase      = 8;
                        end
                    end
                end
                default: m_tag = m_halt_tag;
            endcase
        end
    end

    // Compare design outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (m_live && !done) begin
            n_checks++;
            if (tx_valid !== m_txv) begin
                n_errs++;
                $display("FAIL %s tx_valid got %b expected %b", m_tag, tx_valid, m_txv);
            end
            n_checks++;
            if (presence !== m_pres) begin
                n_errs++;
                $display("FAIL %s presence got %b expected %b", m_ptag, presence, m_pres);
            end
            if (m_txv) begin
                n_checks++;
                if (tx_byte !== m_txb) begin
                    n_errs++;
                    $display("FAIL %s tx_byte got %h expected %h", m_tag, tx_byte, m_txb);
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic req();
        @(negedge clk); tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
    endtask

    task automatic prog();
        @(negedge clk); prog_pulse = 1'b1;
        @(negedge clk); prog_pulse = 1'b0;
    endtask

    task automatic breset();
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
        @(negedge clk);
    endtask

    task automatic header(input logic [7:0] cmd, input logic [15:0] a);
        send(cmd); send(a[7:0]); send(a[15:8]);
    endtask

    // One pass: data byte, CRC readout, commit action, readback.
    task automatic pass(input logic [7:0] d, input bit use_ff);
        send(d); req(); req();
        if (use_ff) send(8'hFF); else prog();
        req();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        req();                                          // R12: idle request ignored
        // R4/R7/R9/R5: data write at 5 then 6
        header(8'h0F, 16'h0005); pass(8'h5A, 1'b0); pass(8'h33, 1'b0);
        breset();                                       // R11
        // R7/R10: AND commit gives 0A, mismatch, then halt
        header(8'h0F, 16'h0005); pass(8'h0F, 1'b0); req(); send(8'h0F);
        breset();
        // R8: status EPROM at 6, then volatile at 7 via FFh, end -> halt
        header(8'h55, 16'h0006); pass(8'hF0, 1'b0); pass(8'h77, 1'b1); req();
        breset();
        // R3/R10: wrapped address reaches last data location
        header(8'h0F, 16'h017E); pass(8'hC3, 1'b0); pass(8'h81, 1'b0); req();
        breset();
        // R2: unknown command, everything ignored
        send(8'hAA); send(8'h0F); req(); prog();
        breset();
        // R6: bad CRC indication commits nothing; verify via rewrite
        header(8'h0F, 16'h0010); send(8'h3C); req(); req(); send(8'h00); req();
        breset();
        header(8'h0F, 16'h0010); pass(8'hFF, 1'b0);
        breset();
        // R6/R8: FFh confirmation not accepted for data or status EPROM
        header(8'h0F, 16'h0020); send(8'h12); req(); req(); send(8'hFF); req();
        breset();
        header(8'h55, 16'h0003); send(8'h00); req(); req(); send(8'hFF); req();
        breset();
        header(8'h55, 16'h0003); pass(8'hFF, 1'b0);
        breset();
        // R11: abort in the middle of the address
        send(8'h55); send(8'h02); breset(); req();
        header(8'h0F, 16'h0040); pass(8'h99, 1'b0);
        breset();
        repeat (4) @(negedge clk);
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_errs++;
            $display("FAIL R12 watchdog got running expected finished");
            finish_run();
        end
    end

endmodule